// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two two's-complement operands of `N` bits each and returns a signed product of `2N` bits. It processes one multiplier bit per clock, from the least significant bit upward. On each step the multiplicand is sign-extended to the product width and shifted to the weight of the current multiplier bit. If that bit is 1, the shifted value goes into a running sum. If it is 0, nothing is added.

The multiplier's top bit has weight −2^(N−1). On that last step the block therefore subtracts the shifted multiplicand: it takes the two's complement (invert, then add one) and adds that. Carries out of the product's top bit are dropped, and the `2N`-bit result is always exact.

A controller holds two states. `ST_IDLE` waits for `start`. Its transition `accept` (idle with `start` high) loads both operands, clears the sum and moves to `ST_RUN`. `ST_RUN` performs one step per cycle. Its transition `step` keeps it in `ST_RUN` while the step index is below `N−1`. Its transition `finish` (the top-bit step) returns it to `ST_IDLE` and schedules the one-cycle `done` pulse. While the block runs, `product` shows the partial sum. After `done`, `product` holds the result.

Top module: `seq_signed_mul`

## Requirements
- R1: `start` sampled high at a rising edge while `busy` is low loads both operands and clears the running sum; `busy` reads 1 in the following cycle.
- R2: `start` sampled high while `busy` is high has no effect: the operands of the run in progress are kept, and the result and `done` timing are those of the original run.
- R3: If `start` is accepted at edge k, `done` is 1 for exactly one cycle after edge k+N. In that cycle `busy` is 0.
- R4: In the `done` cycle, `product` equals the two's-complement product of the operands, `2N` bits wide, with the multiplier's top bit weighted −2^(N−1).
- R5: For N = 4, multiplicand 1010 (−6) times multiplier 1011 (−5) gives 00011110 (+30), and 1010 times 0101 (+5) gives 11100010 (−30).
- R6: Both operands equal to −2^(N−1) give +2^(2N−2) without wrap: 01000000 for N = 4 and 0x4000 for N = 8.
- R7: While `busy` is low and no `start` arrives, `product` does not change.
- R8: Synchronous active-high `rst` makes `busy` and `done` 0 and `product` 0 after the next rising edge, including in the middle of a run.
- R9: A `start` given in the same cycle as `done` is accepted, and a new run begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication |
| multiplicand | input | N | Two's-complement multiplicand |
| multiplier | input | N | Two's-complement multiplier |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| product | output | 2N | Two's-complement product (running sum while busy) |

## Verification
The `finish` transition and the `accept` transition can occur in the same cycle, because `done` is raised just as the controller re-enters `ST_IDLE`. The bench forces this by raising `start` with fresh operands in the cycle where `done` is high. In the next cycle it expects `busy` high and `done` low, and N cycles later it expects the new product. A second overlap, `start` arriving mid-run, is judged by checking that the original product and the original `done` timing are unchanged.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic                  busy,
    output logic                  load,
    output logic                  step_en,
    output logic                  last_step,
    output logic [CW-1:0]         step_idx,
    output logic                  done
);
    import seq_mul_pkg::*;
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

    mul_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;          // accept
            ST_RUN:  if (step_idx == LAST_IDX) state_d = ST_IDLE; // finish
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        load      = 1'b0;
        step_en   = 1'b0;
        last_step = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                busy      = 1'b1;
                step_en   = 1'b1;
                last_step = (step_idx == LAST_IDX);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= step_en && last_step;
            if (load || (step_en && last_step)) step_idx <= '0;
            else if (step_en)                   step_idx <= step_idx + 1'b1;
        end
    end

    // latency checker: cycles since the accepted start
    logic [CW:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (rst)       chk_cnt <= '0;
        else if (load) chk_cnt <= '0;
        else if (busy) chk_cnt <= chk_cnt + 1'b1;
    end

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (chk_cnt == (CW+1)'(N)));
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));
    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);
endmodule

// File: rtl/mul_term.sv
module mul_term #(
    parameter int N = 8
) (
    input  logic [N-1:0]      mcand,
    input  logic              mbit,
    input  logic [CW-1:0]     shift,
    input  logic              negate,
    output logic [2*N-1:0]    term
);
    localparam int PW = 2 * N;
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ext;
    logic [PW-1:0] shifted;
    logic [PW-1:0] picked;

    always_comb begin
        ext     = {{N{mcand[N-1]}}, mcand};
        shifted = ext << shift;
        picked  = mbit ? shifted : '0;
        term    = negate ? (~picked + 1'b1) : picked;
    end
endmodule

// File: rtl/mul_acc.sv
module mul_acc #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          add_en,
    input  logic [PW-1:0] term,
    output logic [PW-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (add_en)  acc <= acc + term;
    end
endmodule

// File: rtl/seq_signed_mul.sv
module seq_signed_mul #(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [N-1:0]      multiplicand,
    input  logic [N-1:0]      multiplier,
    output logic              busy,
    output logic              done,
    output logic [2*N-1:0]    product
);
    localparam int PW = 2 * N;
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic          load, step_en, last_step;
    logic [CW-1:0] step_idx;
    logic [N-1:0]  a_q, b_q;
    logic [PW-1:0] term;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= multiplicand;
            b_q <= multiplier;
        end
    end

    mul_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .load(load),
        .step_en(step_en), .last_step(last_step), .step_idx(step_idx), .done(done)
    );

    mul_term #(.N(N)) u_term (
        .mcand(a_q), .mbit(b_q[step_idx]), .shift(step_idx),
        .negate(last_step), .term(term)
    );

    mul_acc #(.PW(PW)) u_acc (
        .clk(clk), .rst(rst), .clear(load), .add_en(step_en),
        .term(term), .acc(product)
    );

    logic signed [PW-1:0] ref_a, ref_b;
    assign ref_a = $signed({{N{a_q[N-1]}}, a_q});
    assign ref_b = $signed({{N{b_q[N-1]}}, b_q});

    assert_operands_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(a_q) && $stable(b_q)));
    assert_result_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> ($signed(product) == ref_a * ref_b));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (!busy && !done && (product == '0)));
endmodule

// File: tb/sim_seq_signed_mul.sv
module sim_seq_signed_mul;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        start0 = 1'b0, start1 = 1'b0;
    logic [3:0]  a0 = '0, b0 = '0;
    logic [7:0]  a1 = '0, b1 = '0;
    logic        busy0, done0, busy1, done1;
    logic [7:0]  p0;
    logic [15:0] p1;

    seq_signed_mul #(.N(4)) u0 (
        .clk(clk), .rst(rst), .start(start0), .multiplicand(a0), .multiplier(b0),
        .busy(busy0), .done(done0), .product(p0)
    );
    seq_signed_mul #(.N(8)) u1 (
        .clk(clk), .rst(rst), .start(start1), .multiplicand(a1), .multiplier(b1),
        .busy(busy1), .done(done1), .product(p1)
    );

    int checks = 0;
    int errors = 0;

    // {multiplicand, multiplier, expected product} for N = 4
    localparam logic [15:0] VEC4 [9] = '{
        16'hAB1E, 16'hA5E2, 16'h8840, 16'h7731, 16'h87C8,
        16'h0800, 16'h78C8, 16'hFF01, 16'h18F8
    };

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b);
        logic signed [7:0] x, y;
        x = $signed({{4{a[3]}}, a});
        y = $signed({{4{b[3]}}, b});
        return x * y;
    endfunction

    function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
        logic signed [15:0] x, y;
        x = $signed({{8{a[7]}}, a});
        y = $signed({{8{b[7]}}, b});
        return x * y;
    endfunction

    task automatic mul4(input logic [3:0] a, input logic [3:0] b, input logic [7:0] exp, input string req);
        @(negedge clk);
        a0 = a; b0 = b; start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        chk(busy0 == 1'b1, "R1 busy after accept", 16'(busy0), 16'd1);
        repeat (4) @(negedge clk);
        chk(done0 == 1'b1 && p0 == exp, req, {7'd0, done0, p0}, {8'd1, exp});
    endtask

    task automatic mul8(input logic [7:0] a, input logic [7:0] b, input string req);
        logic [15:0] exp;
        exp = ref8(a, b);
        @(negedge clk);
        a1 = a; b1 = b; start1 = 1'b1;
        @(negedge clk);
        start1 = 1'b0;
        repeat (8) @(negedge clk);
        chk(done1 == 1'b1 && p1 == exp, req, p1, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired actual=hang expected=done");
        finish_run();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk(!busy0 && !done0 && p0 == 8'h00, "R8 reset state n4", {busy0, done0, p0}, 16'h0);
        chk(!busy1 && !done1 && p1 == 16'h0, "R8 reset state n8", p1, 16'h0);
        rst = 1'b0;

        // R5 R6: vector table
        for (int i = 0; i < 9; i++)
            mul4(VEC4[i][15:12], VEC4[i][11:8], VEC4[i][7:0], "R5 R6 table");

        // R4: exhaustive N = 4
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                mul4(4'(i), 4'(j), ref4(4'(i), 4'(j)), "R4 exhaustive");

        // R6: N = 8 corner, then R4 random
        mul8(8'h80, 8'h80, "R6 min times min n8");
        mul8(8'h80, 8'h7F, "R4 min times max n8");
        for (int k = 0; k < 200; k++)
            mul8(8'($urandom), 8'($urandom), "R4 random n8");

        // R2: start while busy is ignored; R3 done timing
        @(negedge clk);
        a0 = 4'hA; b0 = 4'hB; start0 = 1'b1;
        @(negedge clk);
        a0 = 4'h3; b0 = 4'h3;                     // start stays high while busy
        @(negedge clk);
        start0 = 1'b0;
        @(negedge clk);
        chk(done0 == 1'b0, "R3 no early done", 16'(done0), 16'd0);
        @(negedge clk);
        chk(done0 == 1'b0 && busy0 == 1'b1, "R3 still busy", {busy0, done0}, 16'h2);
        @(negedge clk);
        chk(done0 == 1'b1 && busy0 == 1'b0, "R3 done after N", {busy0, done0}, 16'h1);
        chk(p0 == 8'h1E, "R2 start while busy ignored", p0, 8'h1E);

        // R9: start in the done cycle
        a0 = 4'h8; b0 = 4'h8; start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        chk(busy0 == 1'b1 && done0 == 1'b0, "R9 accept on done", {busy0, done0}, 16'h2);
        repeat (4) @(negedge clk);
        chk(done0 == 1'b1 && p0 == 8'h40, "R9 back-to-back result", p0, 8'h40);

        // R7: hold after done
        repeat (3) @(negedge clk);
        chk(p0 == 8'h40 && !done0, "R7 product held", p0, 8'h40);
        chk(!done0, "R3 done is one cycle", 16'(done0), 16'd0);

        // R8: reset mid-run
        a0 = 4'h7; b0 = 4'h7; start0 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy0 && !done0 && p0 == 8'h00, "R8 reset mid-run", {busy0, done0, p0}, 16'h0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(!done0 && p0 == 8'h00, "R8 no done after reset", {done0, p0}, 16'h0);

        finish_run();
    end
endmodule